// File: doc/BRIEF.md
# Video field capture decimator

This block chooses, one field at a time, whether an incoming video field reaches the output data port. A one-cycle strobe marks the start of each field, and an odd/even indicator is sampled with that strobe. At each field start the block applies a 3-bit capture mode held in its configuration register and latches a single capture decision. That decision stays fixed for the rest of the field. The per-pixel data-valid signal is qualified by the decision, so every pixel of a rejected field is suppressed.

Capture modes cover no capture, one field in four, alternate fields, alternate fields of one parity, every field of one parity, and all fields. A counter tracks the decimation phase. In the parity-restricted alternate modes it counts only fields of the chosen parity; in every other mode it counts all fields. The configuration register also holds an output-enable bit. The pad ring uses this bit to three-state the luma, chroma, active, sync and data-valid outputs.

Top module: `field_capture_gate`

## Requirements
- R1: After reset the stored capture mode is 000, `out_en_o` is 0 and `cap_valid_o` is 0.
- R2: Mode 000 rejects every field: `cap_valid_o` is 0 after each field start.
- R3: Mode 001 captures the first field after the mode takes effect and then every fourth field, whatever the parity.
- R4: Mode 010 captures the first field after the mode takes effect and then every second field, whatever the parity.
- R5: Mode 011 captures the first odd field after the mode takes effect and then every second odd field. Mode 100 does the same with even fields. A field of the other parity is never captured and does not advance the count.
- R6: Mode 101 captures every odd field, mode 110 every even field, and mode 111 every field. `field_odd_i` = 1 marks an odd field.
- R7: The decision for a field is sampled on the clock edge where `field_start_i` is high. It appears on `cap_valid_o` from the next cycle and holds until the next field start.
- R8: A mode written through `cfg_we_i` has no effect on the current field. It is applied at the next field start. When the applied mode differs from the previous one, the decimation count restarts at zero.
- R9: `dvalid_o` is high exactly when `pix_valid_i` and `cap_valid_o` are both high.
- R10: `out_en_o` takes the value of `cfg_oe_i` in the cycle after a configuration write and keeps it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Capture mode to store |
| cfg_oe_i | input | 1 | Output-enable bit to store |
| field_start_i | input | 1 | One-cycle strobe at the start of a field |
| field_odd_i | input | 1 | 1 for an odd field, sampled with the strobe |
| pix_valid_i | input | 1 | Incoming pixel data valid |
| cap_valid_o | output | 1 | Current field is captured |
| dvalid_o | output | 1 | Qualified pixel data valid |
| out_en_o | output | 1 | Output-enable for the three-state pad drivers |

## Verification
A field decision is registered on the strobe edge, so `cap_valid_o` is due one cycle after `field_start_i`. A configuration write reaches `out_en_o` one cycle after `cfg_we_i`. A written mode first shows in the decision after the next strobe edge. `dvalid_o` is combinational from `pix_valid_i` and `cap_valid_o` with zero latency. Inputs are driven on the falling edge and results are sampled on the next falling edge, which lies after exactly one rising edge.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int MODE_W  = 3;
  localparam int PHASE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CM_NONE      = 3'd0,
    CM_QUARTER   = 3'd1,
    CM_HALF      = 3'd2,
    CM_HALF_ODD  = 3'd3,
    CM_HALF_EVEN = 3'd4,
    CM_ODD       = 3'd5,
    CM_EVEN      = 3'd6,
    CM_ALL       = 3'd7
  } cap_mode_e;

  // Whether this field advances the decimation phase in the given mode.
  function automatic logic field_counts(input cap_mode_e m, input logic odd);
    case (m)
      CM_HALF_ODD:  return odd;
      CM_HALF_EVEN: return !odd;
      default:      return 1'b1;
    endcase
  endfunction

  // Capture decision from mode, parity and phase before advancing.
  function automatic logic take_field(input cap_mode_e m, input logic odd,
                                      input logic [PHASE_W-1:0] ph);
    case (m)
      CM_NONE:      return 1'b0;
      CM_QUARTER:   return ph == '0;
      CM_HALF:      return !ph[0];
      CM_HALF_ODD:  return odd && !ph[0];
      CM_HALF_EVEN: return !odd && !ph[0];
      CM_ODD:       return odd;
      CM_EVEN:      return !odd;
      default:      return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fcd_cfg_regs.sv
module fcd_cfg_regs
  import fcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic            oe_i,
  output cap_mode_e       mode_q,
  output logic            oe_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= CM_NONE;
      oe_q   <= 1'b0;
    end else if (we_i) begin
      mode_q <= cap_mode_e'(mode_i);
      oe_q   <= oe_i;
    end
  end
endmodule

// File: rtl/fcd_mode_track.sv
module fcd_mode_track
  import fcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      field_start_i,
  input  cap_mode_e cfg_mode_i,
  output cap_mode_e active_q,
  output logic      restart_o
);
  // Restart the phase when a field begins under a different mode.
  assign restart_o = field_start_i && (cfg_mode_i != active_q);

  always_ff @(posedge clk) begin
    if (!rst_n)             active_q <= CM_NONE;
    else if (field_start_i) active_q <= cfg_mode_i;
  end
endmodule

// File: rtl/fcd_phase.sv
module fcd_phase
  import fcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               field_start_i,
  input  logic               restart_i,
  input  logic               count_i,
  output logic [PHASE_W-1:0] base_o,
  output logic [PHASE_W-1:0] phase_q
);
  assign base_o = restart_i ? '0 : phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             phase_q <= '0;
    else if (field_start_i) phase_q <= count_i ? base_o + 1'b1 : base_o;
  end
endmodule

// File: rtl/field_capture_gate.sv
module field_capture_gate
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_oe_i,
  input  logic              field_start_i,
  input  logic              field_odd_i,
  input  logic              pix_valid_i,
  output logic              cap_valid_o,
  output logic              dvalid_o,
  output logic              out_en_o
);
  cap_mode_e          mode_cfg;
  cap_mode_e          mode_act;
  logic               phase_restart;
  logic               phase_count;
  logic [PHASE_W-1:0] phase_base;
  logic [PHASE_W-1:0] phase_cur;
  logic               take_now;

  fcd_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .mode_i(cfg_mode_i),
    .oe_i(cfg_oe_i), .mode_q(mode_cfg), .oe_q(out_en_o)
  );

  fcd_mode_track u_track (
    .clk(clk), .rst_n(rst_n), .field_start_i(field_start_i),
    .cfg_mode_i(mode_cfg), .active_q(mode_act), .restart_o(phase_restart)
  );

  assign phase_count = field_counts(mode_cfg, field_odd_i);

  fcd_phase u_phase (
    .clk(clk), .rst_n(rst_n), .field_start_i(field_start_i),
    .restart_i(phase_restart), .count_i(phase_count),
    .base_o(phase_base), .phase_q(phase_cur)
  );

  assign take_now = take_field(mode_cfg, field_odd_i, phase_base);

  always_ff @(posedge clk) begin
    if (!rst_n)             cap_valid_o <= 1'b0;
    else if (field_start_i) cap_valid_o <= take_now;
  end

  assign dvalid_o = pix_valid_i & cap_valid_o;
endmodule

// File: rtl/field_capture_gate_chk.sv
module field_capture_gate_chk
  import fcd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we_i,
  input logic               field_start_i,
  input logic               field_odd_i,
  input logic               pix_valid_i,
  input logic               cap_valid_o,
  input logic               dvalid_o,
  input logic               out_en_o,
  input cap_mode_e          mode_cfg,
  input logic               phase_restart,
  input logic [PHASE_W-1:0] phase_cur
);
  AST_HOLD_IN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start_i |=> $stable(cap_valid_o)); // R7
  AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_i && mode_cfg == CM_NONE |=> !cap_valid_o); // R2
  AST_MODE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_i && mode_cfg == CM_ALL |=> cap_valid_o); // R6
  AST_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    field_start_i && mode_cfg == CM_ODD |=> cap_valid_o == $past(field_odd_i)); // R6
  AST_DVALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> cap_valid_o && pix_valid_i); // R9
  AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we_i |=> $stable(out_en_o)); // R10
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    phase_restart |=> phase_cur <= 2'd1); // R8
endmodule

bind field_capture_gate field_capture_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .field_start_i(field_start_i),
  .field_odd_i(field_odd_i), .pix_valid_i(pix_valid_i),
  .cap_valid_o(cap_valid_o), .dvalid_o(dvalid_o), .out_en_o(out_en_o),
  .mode_cfg(mode_cfg), .phase_restart(phase_restart), .phase_cur(phase_cur)
);

// File: tb/field_capture_gate_test.sv
module field_capture_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_mode_i = 3'd0;
  logic       cfg_oe_i = 1'b0;
  logic       field_start_i = 1'b0;
  logic       field_odd_i = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic       cap_valid_o, dvalid_o, out_en_o;
  int checks = 0;
  int fails = 0;
  logic oe_now = 1'b0;

  always #5 clk = ~clk;

  field_capture_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .cfg_oe_i(cfg_oe_i), .field_start_i(field_start_i), .field_odd_i(field_odd_i),
    .pix_valid_i(pix_valid_i), .cap_valid_o(cap_valid_o), .dvalid_o(dvalid_o),
    .out_en_o(out_en_o)
  );

  // {mode, odd, expected capture}
  localparam int NV = 27;
  localparam logic [4:0] VEC [NV] = '{
    {3'd7,1'b1,1'b1}, {3'd7,1'b0,1'b1},
    {3'd1,1'b1,1'b1}, {3'd1,1'b0,1'b0}, {3'd1,1'b1,1'b0}, {3'd1,1'b0,1'b0}, {3'd1,1'b1,1'b1},
    {3'd2,1'b0,1'b1}, {3'd2,1'b1,1'b0}, {3'd2,1'b0,1'b1},
    {3'd3,1'b1,1'b1}, {3'd3,1'b0,1'b0}, {3'd3,1'b1,1'b0}, {3'd3,1'b0,1'b0}, {3'd3,1'b1,1'b1},
    {3'd4,1'b1,1'b0}, {3'd4,1'b0,1'b1}, {3'd4,1'b0,1'b0}, {3'd4,1'b1,1'b0}, {3'd4,1'b0,1'b1},
    {3'd5,1'b1,1'b1}, {3'd5,1'b0,1'b0},
    {3'd6,1'b0,1'b1}, {3'd6,1'b1,1'b0},
    {3'd0,1'b1,1'b0}, {3'd0,1'b0,1'b0},
    {3'd7,1'b0,1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] m, input logic oe);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_mode_i = m; cfg_oe_i = oe;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic start_field(input logic odd);
    @(negedge clk);
    field_start_i = 1'b1; field_odd_i = odd;
    @(negedge clk);
    field_start_i = 1'b0;
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_en", out_en_o, 1'b0);
    check("R1 cap_valid", cap_valid_o, 1'b0);
    start_field(1'b1);
    check("R1 mode resets to none", cap_valid_o, 1'b0);

    // R10 output enable
    write_cfg(3'd0, 1'b1);
    check("R10 oe set", out_en_o, 1'b1);
    oe_now = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write_cfg(VEC[i][4:2], oe_now);
      start_field(VEC[i][1]);
      check(req_of(VEC[i][4:2]), cap_valid_o, VEC[i][0]);
      pix_valid_i = 1'b1; #1;
      check("R9 dvalid high pix", dvalid_o, VEC[i][0]);
      pix_valid_i = 1'b0; #1;
      check("R9 dvalid low pix", dvalid_o, 1'b0);
    end

    // R7 / R8: mode written mid-field has no effect until next field start
    write_cfg(3'd7, 1'b1);
    start_field(1'b0);
    check("R7 captured", cap_valid_o, 1'b1);
    write_cfg(3'd0, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 current field kept", cap_valid_o, 1'b1);
    check("R7 held", cap_valid_o, 1'b1);
    start_field(1'b1);
    check("R8 applied at boundary", cap_valid_o, 1'b0);

    // R8: phase restart when mode changes mid-sequence
    write_cfg(3'd2, 1'b1);
    start_field(1'b1);
    check("R4 first after change", cap_valid_o, 1'b1);
    write_cfg(3'd1, 1'b1);
    start_field(1'b0);
    check("R8 restart on change", cap_valid_o, 1'b1);
    start_field(1'b0);
    check("R3 second field", cap_valid_o, 1'b0);

    // R7: decision visible only one cycle after strobe
    write_cfg(3'd7, 1'b1);
    @(negedge clk);
    field_start_i = 1'b1; field_odd_i = 1'b1;
    #1 check("R7 not before edge", cap_valid_o, 1'b0);
    @(negedge clk);
    field_start_i = 1'b0;
    check("R7 after edge", cap_valid_o, 1'b1);

    // R10 clear
    write_cfg(3'd7, 1'b0);
    check("R10 oe cleared", out_en_o, 1'b0);
    repeat (3) @(negedge clk);
    check("R10 oe held", out_en_o, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule